// File: doc/BRIEF.md
# Battery Voltage Peak-Drop Terminator

This block watches the battery voltage during fast charge and ends the charge once the voltage has passed its peak. It receives a stream of ADC conversion codes with a valid strobe. Each pulse of the slow sample tick starts a new sample. The block then adds up a fixed number of valid conversions and keeps their floor average as that sample. In-window samples feed a running maximum. A sample that lies far enough below that maximum raises a sticky terminate flag.

A two-bit select chooses the detection scheme. The fine-step scheme uses a deeper average (32 conversions) and a small drop step. The coarse-step scheme uses 16 conversions and a larger drop step. The select can also switch the detector off. The charge controller pulses `cycleStart` at every new charge cycle. It holds `enable` low during the hold-off period after fast charge begins: the peak keeps being tracked, but termination is withheld.

Top module: `vdrop_detector`

## Requirements
- R1: After reset, and on the clock edge after `cycleStart` is high, `terminate` is 0 and the tracked peak is cleared to zero, so no sample can terminate until a new peak has been built.
- R2: With `modeSel` at 2'b00 (off) or 2'b11 (treated as off), sample ticks are ignored, no sample is formed and `terminate` never rises.
- R3: With `modeSel` at 2'b10 (fine mode), a sample is the average of `PVD_DEPTH` (32) valid conversions. It terminates when sample + `PVD_STEP` (2) <= peak.
- R4: With `modeSel` at 2'b01 (coarse mode), a sample is the average of `NDV_DEPTH` (16) valid conversions. It terminates when sample + `NDV_STEP` (4) <= peak.
- R5: A drop smaller than the active step does not terminate.
- R6: A sample counts only if winLo < sample < winHi (strict). A sample outside that window neither updates the peak nor terminates.
- R7: While `enable` is 0, no termination occurs, but in-window samples still raise the peak.
- R8: Once set, `terminate` stays 1 until `cycleStart`, whatever the later samples, `enable` or mode.
- R9: A sample tick that arrives while a sample is being collected is ignored. Cycles with `adcValid` low are not counted and do not add to the sum.
- R10: The mode is taken when the sample tick is accepted. A later change of `modeSel` does not change the depth or the step of that sample.
- R11: The average is the floor of sum/depth, with no rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStart | input | 1 | New charge cycle: clears peak, flag and any sample in progress |
| enable | input | 1 | Termination permitted (low during hold-off) |
| modeSel | input | 2 | 00 off, 01 coarse step, 10 fine step, 11 off |
| sampleTick | input | 1 | Starts the collection of one sample |
| adcValid | input | 1 | `adcCode` holds a new conversion |
| adcCode | input | ADC_W | Battery voltage conversion code |
| winLo | input | ADC_W | Exclusive lower limit of the valid window |
| winHi | input | ADC_W | Exclusive upper limit of the valid window |
| terminate | output | 1 | Sticky terminate request |

## Verification
When the last counted conversion is sampled at clock edge N, the averaged sample is registered at edge N, and the peak and `terminate` change at edge N+1. The bench drives its inputs on falling edges. It waits two falling edges after the last conversion before it reads `terminate`, and it reads the reset state one falling edge after `cycleStart`. Every other result follows from an arithmetic model of peak and flag that the bench updates once per sample. Drop sweeps across both modes cover each step boundary.

// File: rtl/vdrop_pkg.sv
package vdrop_pkg;
  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_NDV = 2'b01;
  localparam logic [1:0] MODE_PVD = 2'b10;

  typedef struct packed {
    logic clear;
    logic start;
    logic add;
    logic last;
    logic pvdMode;
  } detStrobe_t;
endpackage

// File: rtl/vdrop_ctrl.sv
module vdrop_ctrl
  import vdrop_pkg::*;
#(
  parameter int PVD_DEPTH = 32,
  parameter int NDV_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStart,
  input  logic       sampleTick,
  input  logic       adcValid,
  input  logic [1:0] modeSel,
  output detStrobe_t strb
);
  localparam int CNT_W = $clog2(PVD_DEPTH);
  localparam logic [CNT_W-1:0] PVD_LAST = CNT_W'(PVD_DEPTH - 1);
  localparam logic [CNT_W-1:0] NDV_LAST = CNT_W'(NDV_DEPTH - 1);

  logic             collecting;
  logic             pvdLatched;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;
  logic             modeOn;

  always_comb begin
    modeOn       = (modeSel == MODE_NDV) || (modeSel == MODE_PVD);
    lastIdx      = pvdLatched ? PVD_LAST : NDV_LAST;
    strb.clear   = cycleStart;
    strb.start   = !cycleStart && !collecting && sampleTick && modeOn;
    strb.add     = !cycleStart && collecting && adcValid;
    strb.last    = !cycleStart && collecting && adcValid && (cnt == lastIdx);
    strb.pvdMode = pvdLatched;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collecting <= 1'b0;
      pvdLatched <= 1'b0;
      cnt        <= '0;
    end else if (cycleStart) begin
      collecting <= 1'b0;
      cnt        <= '0;
    end else if (strb.start) begin
      collecting <= 1'b1;
      pvdLatched <= (modeSel == MODE_PVD);
      cnt        <= '0;
    end else if (strb.add) begin
      cnt <= cnt + 1'b1;
      if (strb.last) collecting <= 1'b0;
    end
  end
endmodule

// File: rtl/vdrop_dp.sv
module vdrop_dp
  import vdrop_pkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int PVD_DEPTH = 32,
  parameter int NDV_DEPTH = 16,
  parameter int PVD_STEP  = 2,
  parameter int NDV_STEP  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  detStrobe_t       strb,
  input  logic [ADC_W-1:0] adcCode,
  input  logic             enable,
  input  logic [ADC_W-1:0] winLo,
  input  logic [ADC_W-1:0] winHi,
  output logic             smpStrobe,
  output logic [ADC_W-1:0] smpValue,
  output logic             terminate
);
  localparam int PVD_SH = $clog2(PVD_DEPTH);
  localparam int NDV_SH = $clog2(NDV_DEPTH);
  localparam int SUM_W  = ADC_W + PVD_SH;
  localparam logic [ADC_W:0] PVD_STEP_V = (ADC_W+1)'(PVD_STEP);
  localparam logic [ADC_W:0] NDV_STEP_V = (ADC_W+1)'(NDV_STEP);

  logic [SUM_W-1:0] acc, accNext, avgWide;
  logic [ADC_W-1:0] peak;
  logic             smpPvd;
  logic [ADC_W:0]   stepVal;
  logic             inWin, dropHit;

  always_comb begin
    accNext = acc + SUM_W'(adcCode);
    avgWide = strb.pvdMode ? (accNext >> PVD_SH) : (accNext >> NDV_SH);
    stepVal = smpPvd ? PVD_STEP_V : NDV_STEP_V;
    inWin   = (smpValue > winLo) && (smpValue < winHi);
    dropHit = ({1'b0, smpValue} + stepVal) <= {1'b0, peak};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      smpStrobe <= 1'b0;
      smpValue  <= '0;
      smpPvd    <= 1'b0;
    end else if (strb.clear) begin
      acc       <= '0;
      smpStrobe <= 1'b0;
    end else begin
      smpStrobe <= strb.last;
      if (strb.start) acc <= '0;
      else if (strb.add) acc <= accNext;
      if (strb.last) begin
        smpValue <= avgWide[ADC_W-1:0];
        smpPvd   <= strb.pvdMode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peak      <= '0;
      terminate <= 1'b0;
    end else if (strb.clear) begin
      peak      <= '0;
      terminate <= 1'b0;
    end else if (smpStrobe && inWin) begin
      if (enable && dropHit) terminate <= 1'b1;
      if (smpValue > peak) peak <= smpValue;
    end
  end
endmodule

// File: rtl/vdrop_detector.sv
module vdrop_detector
  import vdrop_pkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int PVD_DEPTH = 32,
  parameter int NDV_DEPTH = 16,
  parameter int PVD_STEP  = 2,
  parameter int NDV_STEP  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStart,
  input  logic             enable,
  input  logic [1:0]       modeSel,
  input  logic             sampleTick,
  input  logic             adcValid,
  input  logic [ADC_W-1:0] adcCode,
  input  logic [ADC_W-1:0] winLo,
  input  logic [ADC_W-1:0] winHi,
  output logic             terminate
);
  detStrobe_t       strb;
  logic             smpStrobe;
  logic [ADC_W-1:0] smpValue;

  vdrop_ctrl #(.PVD_DEPTH(PVD_DEPTH), .NDV_DEPTH(NDV_DEPTH)) ctrlI (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .sampleTick(sampleTick),
    .adcValid(adcValid), .modeSel(modeSel), .strb(strb)
  );

  vdrop_dp #(
    .ADC_W(ADC_W), .PVD_DEPTH(PVD_DEPTH), .NDV_DEPTH(NDV_DEPTH),
    .PVD_STEP(PVD_STEP), .NDV_STEP(NDV_STEP)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .adcCode(adcCode), .enable(enable),
    .winLo(winLo), .winHi(winHi), .smpStrobe(smpStrobe), .smpValue(smpValue),
    .terminate(terminate)
  );
endmodule

// File: rtl/vdrop_detector_chk.sv
module vdrop_detector_chk #(
  parameter int ADC_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleStart,
  input logic             enable,
  input logic             terminate,
  input logic             smpStrobe,
  input logic [ADC_W-1:0] smpValue,
  input logic [ADC_W-1:0] winLo,
  input logic [ADC_W-1:0] winHi
);
  // R1
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !terminate);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !cycleStart) |=> terminate);

  // R7
  holdoff_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(terminate) |-> $past(enable));

  // R3
  rise_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(terminate) |-> $past(smpStrobe));

  // R6
  rise_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(terminate) |-> ($past(smpValue) > $past(winLo) && $past(smpValue) < $past(winHi)));
endmodule

bind vdrop_detector vdrop_detector_chk #(.ADC_W(ADC_W)) chkI (
  .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .enable(enable),
  .terminate(terminate), .smpStrobe(smpStrobe), .smpValue(smpValue),
  .winLo(winLo), .winHi(winHi)
);

// File: tb/vdrop_detector_test.sv
module vdrop_detector_test;
  localparam int W = 10;
  logic clk = 0, rstN = 0, cycleStart = 0, enable = 1, sampleTick = 0, adcValid = 0;
  logic [1:0] modeSel = 2'b10;
  logic [W-1:0] adcCode = '1, winLo = 10'd200, winHi = 10'd800;
  logic terminate;
  int errors = 0, checks = 0;
  int mPeak = 0;
  bit mTerm = 0, done = 0;

  always #5 clk = ~clk;

  vdrop_detector uut (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .enable(enable), .modeSel(modeSel),
    .sampleTick(sampleTick), .adcValid(adcValid), .adcCode(adcCode), .winLo(winLo),
    .winHi(winHi), .terminate(terminate)
  );

  task automatic check(input string req);
    checks++;
    if (terminate !== mTerm) begin
      errors++;
      $display("FAIL %s: terminate=%0b expected=%0b", req, terminate, mTerm);
    end
  endtask

  task automatic restart(input string req);
    @(negedge clk) cycleStart = 1;
    @(negedge clk) cycleStart = 0;
    mPeak = 0; mTerm = 0;
    check(req);
  endtask

  // One sample: n conversions of base, the first 'extra' of them base+1.
  task automatic runSample(input int base, input int extra, input bit midTick,
                           input logic [1:0] altMode, input string req);
    logic [1:0] m = modeSel;
    int n = (m == 2'b10) ? 32 : 16;
    int step = (m == 2'b10) ? 2 : 4;
    int avg;
    @(negedge clk) sampleTick = 1;
    @(negedge clk) begin sampleTick = 0; modeSel = altMode; end
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 1) begin @(negedge clk) begin adcValid = 0; adcCode = '1; end end
      @(negedge clk) begin
        adcValid = 1; adcCode = W'((i < extra) ? base + 1 : base);
        sampleTick = midTick && (i == n / 2);
      end
    end
    @(negedge clk) begin adcValid = 0; adcCode = '1; sampleTick = 0; end
    @(negedge clk);
    if (m == 2'b10 || m == 2'b01) begin
      avg = (n * base + extra) / n;
      if (avg > int'(winLo) && avg < int'(winHi)) begin
        if (enable && avg + step <= mPeak) mTerm = 1;
        if (avg > mPeak) mPeak = avg;
      end
    end
    modeSel = m;
    check(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk) check("R1 reset");
    // Drop sweeps in both modes
    for (int md = 1; md <= 2; md++) begin
      for (int d = 0; d <= 6; d++) begin
        modeSel = 2'(md);
        restart("R1");
        runSample(600, 0, 0, modeSel, "R3/R4 peak build");
        runSample(600 - d, 0, 0, modeSel, (md == 2) ? "R3 R5 fine drop" : "R4 R5 coarse drop");
      end
    end
    // Floor averaging
    modeSel = 2'b01; restart("R1");
    runSample(600, 0, 0, 2'b01, "R11");
    runSample(596, 15, 0, 2'b01, "R11 coarse floor");
    modeSel = 2'b10; restart("R1");
    runSample(600, 0, 0, 2'b10, "R11");
    runSample(598, 31, 0, 2'b10, "R11 fine floor");
    // Disabled modes
    restart("R1");
    runSample(600, 0, 0, 2'b10, "R2");
    modeSel = 2'b00; runSample(500, 0, 0, 2'b00, "R2 off");
    modeSel = 2'b11; runSample(500, 0, 0, 2'b11, "R2 code 11");
    modeSel = 2'b10; runSample(599, 0, 0, 2'b10, "R2 peak untouched");
    // Window
    restart("R1");
    runSample(600, 0, 0, 2'b10, "R6");
    runSample(150, 0, 0, 2'b10, "R6 below window");
    runSample(200, 0, 0, 2'b10, "R6 at low edge");
    runSample(850, 0, 0, 2'b10, "R6 above window");
    runSample(800, 0, 0, 2'b10, "R6 at high edge");
    runSample(599, 0, 0, 2'b10, "R6 peak not raised");
    runSample(598, 0, 0, 2'b10, "R6 in-window drop");
    // Hold-off
    restart("R1"); enable = 0;
    runSample(600, 0, 0, 2'b10, "R7");
    runSample(500, 0, 0, 2'b10, "R7 suppressed");
    runSample(700, 0, 0, 2'b10, "R7 peak tracked");
    enable = 1;
    runSample(697, 0, 0, 2'b10, "R7 after hold-off");
    // Sticky
    runSample(790, 0, 0, 2'b10, "R8 sticky rise");
    enable = 0;
    runSample(600, 0, 0, 2'b10, "R8 sticky enable low");
    enable = 1; modeSel = 2'b00;
    runSample(600, 0, 0, 2'b00, "R8 sticky mode off");
    modeSel = 2'b10;
    restart("R8 cleared by restart");
    runSample(300, 0, 0, 2'b10, "R1 peak cleared");
    // Mid tick and invalid cycles
    restart("R1");
    runSample(600, 0, 0, 2'b10, "R9");
    runSample(590, 0, 1, 2'b10, "R9 tick ignored mid-sample");
    // Mode latched at tick
    restart("R1");
    runSample(500, 0, 0, 2'b10, "R10");
    runSample(498, 0, 0, 2'b01, "R10 mode latched");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: terminate=%0b expected=finish", terminate);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule